// File: doc/BRIEF.md
# Block-Transfer DMA Disk Controller

This block is the register and bus-master core of a disk controller. Software sets a memory start address and then writes a command word that holds a track, a sector and a direction. That write launches one autonomous move of a fixed-size block, 1,024 bytes by default. The block moves the bytes between main memory and a byte-stream port that faces the sector buffer, and the CPU takes no further part. When the move ends, the block raises an interrupt. Software acknowledges it by reading the status register.

The controller takes the shared memory bus through a request/grant handshake. It issues byte-wide memory cycles only while it holds the grant. While it owns the bus it flags `cpu_stall`, which holds the CPU off the bus; the CPU can carry on with internal work. The system arbiter is expected to keep the grant for as long as the request stays high.

The disk side has two valid/ready byte streams, with these rules:
- Outgoing stream (`tx_*`), used when writing to the disk. Once `tx_valid` rises, it and `tx_data` stay unchanged until a cycle in which `tx_ready` is high.
- Incoming stream (`rx_*`), used when reading from the disk. `rx_ready` is high only while the one-byte holding register is empty.
- Memory cycles. `mem_en` stays high, with a stable address and stable write data, until `mem_ack`.

Seek timing, mechanics and error correction lie outside this block.

Top module: `blkdma_ctrl`

## Requirements
- R1: After reset, `irq`, `bus_req`, `cpu_stall`, `mem_en`, `tx_valid`, `rx_ready` and `dsk_go` are all 0, and the status register reads 0.
- R2: The register window starts at 0xCF00. The command register is at 0xCF00 and reads back the last accepted command. The 16-bit memory-address register is at 0xCF04 and can be written and read. The status register is at 0xCF08, with bit 0 = busy, bit 1 = done and bit 2 = error.
- R3: The command word layout is: bits 15:6 track (0 to 1023), bits 5:1 sector, and bit 0 direction (1 = memory to disk, 0 = disk to memory). A command written while idle is accepted. On the cycle after the write, `dsk_track`, `dsk_sector` and `dsk_write` show its fields, and `dsk_go` is high for exactly that one cycle.
- R4: `bus_req` rises on the cycle after an accepted command write. No memory cycle is issued while `bus_gnt` is low. `cpu_stall` is high while the block holds the grant during a transfer.
- R5: In a memory-to-disk transfer, the block reads 1,024 bytes at addresses start, start+1, … (modulo 2^16). It sends each byte, in order, on the outgoing stream.
- R6: In a disk-to-memory transfer, the block accepts 1,024 bytes from the incoming stream. It writes byte i to address start+i (modulo 2^16).
- R7: Back-pressure rules. An offered outgoing byte stays stable until it is accepted. A pending memory cycle keeps its address until it is acknowledged.
- R8: On the cycle after the final byte handshake, `bus_req` and busy are 0, and done and `irq` are 1.
- R9: A read of the status register returns the current bits. It clears done and error at that edge, so `irq` is 0 on the following cycle.
- R10: A command write while busy is ignored: the transfer continues unchanged, and the command fields and command readback keep their values. The write sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | CPU register access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| irq | output | 1 | Completion interrupt (level) |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| cpu_stall | output | 1 | Holds the CPU off the bus while the block owns it |
| mem_en | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory cycle completes this cycle |
| dsk_go | output | 1 | One-cycle pulse when a command is accepted |
| dsk_track | output | 10 | Track of the accepted command |
| dsk_sector | output | 5 | Sector of the accepted command |
| dsk_write | output | 1 | 1 = memory to disk |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sector buffer accepts byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block accepts incoming byte |
| rx_data | input | 8 | Incoming byte |

## Verification
Register effects are due one edge after the CPU access. `dsk_go`, `bus_req` and busy are checked in the low phase right after the command's access edge, and read data is sampled in the low phase of the access cycle itself. Byte results are compared as each handshake completes: the monitor samples `tx_valid && tx_ready` and `mem_en && mem_ack` at the falling edge before the completing rising edge and pops the expected item from the queue. Completion is checked in the low phase after the final handshake edge, where `irq` must be high and `bus_req` low. The interrupt clear is checked one cycle after the status read. Memory acknowledges, outgoing readiness and incoming validity follow different cyclic gap patterns, so stalls land on every state.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  localparam int OFF_CMD  = 0;
  localparam int OFF_MAR  = 4;
  localparam int OFF_STAT = 8;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;

  localparam int CMD_DIR_BIT  = 0;
  localparam int CMD_SEC_LSB  = 1;
  localparam int CMD_SEC_W    = 5;
  localparam int CMD_TRK_LSB  = CMD_SEC_LSB + CMD_SEC_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARB,
    S_MRD,
    S_TX,
    S_RX,
    S_MWR
  } eng_state_e;
endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              busy,
  input  logic              done_pulse,
  output logic              start,
  output logic              go_q,
  output logic [REG_W-1:0]  cmd_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD  = BASE_ADDR + ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_MAR  = BASE_ADDR + ADDR_W'(OFF_MAR);
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFF_STAT);

  logic done_q, err_q;
  logic wr_cmd, wr_mar, rd_stat;

  assign wr_cmd  = cpu_sel && cpu_we && (cpu_addr == A_CMD);
  assign wr_mar  = cpu_sel && cpu_we && (cpu_addr == A_MAR);
  assign rd_stat = cpu_sel && !cpu_we && (cpu_addr == A_STAT);
  assign start   = wr_cmd && !busy;
  assign irq     = done_q;

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == A_CMD) begin
      cpu_rdata = cmd_q;
    end else if (cpu_addr == A_MAR) begin
      cpu_rdata = REG_W'(mar_q);
    end else if (cpu_addr == A_STAT) begin
      cpu_rdata[ST_BUSY] = busy;
      cpu_rdata[ST_DONE] = done_q;
      cpu_rdata[ST_ERR]  = err_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mar_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q <= start;
      if (start) cmd_q <= cpu_wdata;
      if (wr_mar) mar_q <= cpu_wdata[ADDR_W-1:0];
      if (done_pulse) done_q <= 1'b1;
      else if (rd_stat) done_q <= 1'b0;
      if (wr_cmd && busy) err_q <= 1'b1;
      else if (rd_stat) err_q <= 1'b0;
    end
  end

  p_busy_cmd_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> err_q);
  p_cmd_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> $stable(cmd_q));
  p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !done_pulse) |=> !irq);
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int BLOCK_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_disk,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done_pulse,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cpu_stall,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data
);
  localparam int CNT_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_BYTES - 1);

  eng_state_e        st;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hold;
  logic              dir;
  logic              last, mem_fire, tx_fire;

  assign last      = (cnt == LAST);
  assign busy      = (st != S_IDLE);
  assign bus_req   = busy;
  assign cpu_stall = busy && bus_gnt;
  assign mem_en    = bus_gnt && ((st == S_MRD) || (st == S_MWR));
  assign mem_we    = (st == S_MWR);
  assign mem_addr  = cur_addr;
  assign mem_wdata = hold;
  assign tx_valid  = (st == S_TX);
  assign tx_data   = hold;
  assign rx_ready  = (st == S_RX);
  assign mem_fire  = mem_en && mem_ack;
  assign tx_fire   = tx_valid && tx_ready;
  assign done_pulse = last && ((tx_fire) || (mem_fire && mem_we));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      cnt      <= '0;
      hold     <= '0;
      dir      <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st       <= S_ARB;
          cur_addr <= base_addr;
          cnt      <= '0;
          dir      <= to_disk;
        end
        S_ARB: if (bus_gnt) st <= dir ? S_MRD : S_RX;
        S_MRD: if (mem_fire) begin
          hold <= mem_rdata;
          st   <= S_TX;
        end
        S_TX: if (tx_ready) begin
          cur_addr <= cur_addr + ADDR_W'(1);
          cnt      <= cnt + CNT_W'(1);
          st       <= last ? S_IDLE : S_MRD;
        end
        S_RX: if (rx_valid) begin
          hold <= rx_data;
          st   <= S_MWR;
        end
        S_MWR: if (mem_fire) begin
          cur_addr <= cur_addr + ADDR_W'(1);
          cnt      <= cnt + CNT_W'(1);
          st       <= last ? S_IDLE : S_RX;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_ack) |=> (mem_en && $stable(mem_addr)));
  p_no_mem_wo_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> !mem_en);
endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W = 16,
  parameter int BYTE_W = 8,
  parameter int BLOCK_BYTES = 1024,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cpu_stall,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              dsk_go,
  output logic [REG_W-CMD_TRK_LSB-1:0] dsk_track,
  output logic [CMD_SEC_W-1:0] dsk_sector,
  output logic              dsk_write,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data
);
  logic              busy, done_pulse, start;
  logic [REG_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] mar_q;

  blkdma_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .done_pulse(done_pulse), .start(start), .go_q(dsk_go),
    .cmd_q(cmd_q), .mar_q(mar_q), .irq(irq)
  );

  blkdma_engine #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BLOCK_BYTES(BLOCK_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .to_disk(cpu_wdata[CMD_DIR_BIT]),
    .base_addr(mar_q), .busy(busy), .done_pulse(done_pulse), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cpu_stall(cpu_stall), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  assign dsk_track  = cmd_q[REG_W-1:CMD_TRK_LSB];
  assign dsk_sector = cmd_q[CMD_TRK_LSB-1:CMD_SEC_LSB];
  assign dsk_write  = cmd_q[CMD_DIR_BIT];

  p_req_drop_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> irq);
  p_go_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_go |-> bus_req);
  p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dsk_go) |=> $stable(cmd_q));
endmodule

// File: tb/tb_blkdma_ctrl.sv
module tb_blkdma_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cpu_sel = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic        irq, bus_req, cpu_stall, mem_en, mem_we, mem_ack, dsk_go, dsk_write;
  logic        bus_gnt = 0, tx_ready = 0, rx_valid = 0, tx_valid, rx_ready;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, tx_data, rx_data = 0;
  logic [9:0]  dsk_track;
  logic [4:0]  dsk_sector;

  logic ack_en = 0, gnt_en = 0;
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;

  blkdma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_stall(cpu_stall), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dsk_go(dsk_go),
    .dsk_track(dsk_track), .dsk_sector(dsk_sector), .dsk_write(dsk_write),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  function automatic logic [7:0] mem_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] dsk_pat(input int i);
    return 8'((i * 7) + 3);
  endfunction

  assign mem_ack   = mem_en && ack_en;
  assign mem_rdata = mem_pat(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [23:0] exp_q[$];
  logic [15:0] rd_base = 0;
  int          rd_cnt = 0, xfer_cnt = 0;
  bit          rx_hs = 0, tx_wait = 0;
  logic [7:0]  tx_prev = 0;

  always @(negedge clk) begin
    logic [23:0] it;
    if (rst_n) begin
      if (tx_wait) chk(tx_valid && tx_data == tx_prev, "R7 tx hold",
                       {23'd0, tx_valid}, 32'd1);
      tx_wait = tx_valid && !tx_ready;
      tx_prev = tx_data;
      if (bus_req && !bus_gnt) chk(!mem_en, "R4 no cycle without grant",
                                   {31'd0, mem_en}, 32'd0);
      if (mem_en && !mem_we && mem_ack) begin
        chk(mem_addr == 16'(rd_base + rd_cnt), "R5 read address", mem_addr,
            16'(rd_base + rd_cnt));
        rd_cnt++;
      end
      if (tx_valid && tx_ready) begin
        xfer_cnt++;
        if (exp_q.size() == 0) chk(0, "R5 unexpected tx byte", tx_data, 0);
        else begin
          it = exp_q.pop_front();
          chk(tx_data == it[7:0], "R5 tx byte", tx_data, it[7:0]);
        end
      end
      if (mem_en && mem_we && mem_ack) begin
        xfer_cnt++;
        if (exp_q.size() == 0) chk(0, "R6 unexpected mem write", mem_addr, 0);
        else begin
          it = exp_q.pop_front();
          chk({mem_addr, mem_wdata} == it, "R6 mem write", {mem_addr, mem_wdata}, it);
        end
      end
      rx_hs = rx_valid && rx_ready;
    end
  end

  // stimulus for arbiter, memory wait states and disk streams
  int rx_idx = 0, rx_lim = 0;
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      bus_gnt  = bus_req && gnt_en;
      ack_en   = (cyc % 4) != 1;
      tx_ready = (cyc % 3) != 0;
      if (rx_hs) begin
        rx_idx++;
        rx_valid = 0;
        rx_hs = 0;
      end
      if (!rx_valid && rx_idx < rx_lim && (cyc % 5) != 2) begin
        rx_valid = 1;
        rx_data  = dsk_pat(rx_idx);
      end
    end
  end

  task automatic reg_wr(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_we = 0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
    @(posedge clk); #1;
    cpu_sel = 0;
  endtask

  task automatic push_tx(input logic [15:0] base);
    for (int i = 0; i < 1024; i++) exp_q.push_back({16'(base + i), mem_pat(16'(base + i))});
  endtask

  task automatic push_rx(input logic [15:0] base);
    for (int i = 0; i < 1024; i++) exp_q.push_back({16'(base + i), dsk_pat(i)});
  endtask

  task automatic wait_irq();
    int n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 20000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk({irq, bus_req, cpu_stall, mem_en, tx_valid, rx_ready, dsk_go} == 7'd0,
        "R1 reset outputs", {irq, bus_req, cpu_stall, mem_en, tx_valid, rx_ready, dsk_go}, 0);
    reg_rd(16'hCF08, d);
    chk(d == 16'h0000, "R1 reset status", d, 16'h0000);

    // memory to disk, track 159 sector 5
    reg_wr(16'hCF04, 16'h3000);
    reg_rd(16'hCF04, d);
    chk(d == 16'h3000, "R2 address register readback", d, 16'h3000);
    rd_base = 16'h3000; rd_cnt = 0; xfer_cnt = 0;
    push_tx(16'h3000);
    reg_wr(16'hCF00, 16'h27CB);
    @(negedge clk);
    chk(dsk_go && bus_req, "R4 go and request after command", {dsk_go, bus_req}, 2'b11);
    chk(dsk_track == 10'd159 && dsk_sector == 5'd5 && dsk_write,
        "R3 command fields", {dsk_track, dsk_sector, dsk_write}, {10'd159, 5'd5, 1'b1});
    @(negedge clk);
    chk(!dsk_go, "R3 go pulse one cycle", dsk_go, 0);
    chk(!mem_en && !cpu_stall, "R4 idle bus while grant withheld", {mem_en, cpu_stall}, 0);
    gnt_en = 1;
    repeat (20) @(negedge clk);
    chk(cpu_stall, "R4 cpu stalled while owning bus", cpu_stall, 1);
    reg_wr(16'hCF00, 16'hFFFF);
    @(negedge clk);
    chk(dsk_track == 10'd159 && dsk_write, "R10 fields kept after busy command",
        dsk_track, 10'd159);
    wait_irq();
    chk(irq && !bus_req && !cpu_stall, "R8 completion", {irq, bus_req, cpu_stall}, 3'b100);
    chk(xfer_cnt == 1024 && exp_q.size() == 0, "R5 byte count", xfer_cnt, 1024);
    reg_rd(16'hCF00, d);
    chk(d == 16'h27CB, "R10 command readback unchanged", d, 16'h27CB);
    reg_rd(16'hCF08, d);
    chk(d == 16'h0006, "R9 status done and error", d, 16'h0006);
    @(negedge clk);
    chk(!irq, "R9 interrupt cleared", irq, 0);
    reg_rd(16'hCF08, d);
    chk(d == 16'h0000, "R9 status cleared", d, 16'h0000);

    // disk to memory, track 3 sector 31, address wraps
    reg_wr(16'hCF04, 16'hFE80);
    xfer_cnt = 0; rx_idx = 0; rx_lim = 1024;
    push_rx(16'hFE80);
    reg_wr(16'hCF00, 16'h00FE);
    @(negedge clk);
    chk(dsk_track == 10'd3 && dsk_sector == 5'd31 && !dsk_write,
        "R3 read command fields", {dsk_track, dsk_sector, dsk_write}, {10'd3, 5'd31, 1'b0});
    reg_rd(16'hCF08, d);
    chk(d == 16'h0001, "R2 busy bit", d, 16'h0001);
    wait_irq();
    chk(irq && !bus_req, "R8 read completion", {irq, bus_req}, 2'b10);
    chk(xfer_cnt == 1024 && exp_q.size() == 0, "R6 byte count", xfer_cnt, 1024);
    reg_rd(16'hCF08, d);
    chk(d == 16'h0002, "R9 done without error", d, 16'h0002);
    @(negedge clk);
    chk(!irq, "R9 interrupt cleared again", irq, 0);

    summary();
    $finish;
  end
endmodule